// File: doc/BRIEF.md
# Log-Structured Append Allocator

This block places new records in a circular, log-structured region of flash. Each incoming SET asks for room for a record made of a fixed-size header, followed by the key and then the value. The allocator picks the byte address where that record starts. It reports that address so the caller can store it in its hash-table entry. It also emits a write descriptor that tells the flash writer where the header, key and value belong. Records are laid down one after another in the order their requests arrive, so the write address stream only moves forward. The one exception is a jump back to the region base when the end of the region is reached.

A DELETE request is accepted and then ignored here. Removing an item only drops its index entry, and the stale bytes in the log are left for a separate background reclaim process. That reclaim process drives a tail offset, which marks the oldest byte still in use. The allocator stalls a SET (holds its ready low) whenever the free gap between its head and that tail is too small for the record. Every record length is rounded up to a configurable alignment, so every record starts on an aligned boundary.

Top module: `lsa_append_alloc`

## Requirements
- R1: After reset no response or descriptor is issued until a SET is accepted, and the first accepted SET (with tail offset 0) is placed at the region base address.
- R2: The record length reported on `wr_len` is HDR_BYTES + key length + value length, rounded up to the next multiple of 2^ALIGN_LG bytes. Every record address is a multiple of that alignment above the base.
- R3: Within a record the key starts HDR_BYTES after the record address, and the value starts right after the key (`wr_val_addr` = `wr_key_addr` + key length).
- R4: A SET that needs no wrap is placed at the current head. The head then moves forward by the record length, so successive records that do not wrap are contiguous.
- R5: Exactly one cycle after a SET is accepted, `rsp_valid` and `wr_valid` are high together for one cycle and carry the same address. In any cycle after which no SET was accepted, both are low.
- R6: A DELETE (`req_op` = 1) is always accepted, produces no response and no descriptor, and leaves the head where it was.
- R7: When the tail offset is greater than the head offset, a SET is accepted only if head + length is strictly less than the tail. While it is stalled nothing is issued and the head does not move.
- R8: When the tail offset is not greater than the head offset and head + length goes past the region end, the record is placed at the base with `rsp_wrapped` = 1 if length < tail offset. Otherwise it stalls. After a wrap the head is at base + length.
- R9: A record that ends exactly at the region end is placed at the head without wrapping when the tail offset is nonzero, and the next head is the base. With tail offset 0 the same request stalls.
- R10: The accept decision uses the tail offset present in the same cycle as the request, so a tail advance lets a stalled SET through in that very cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 1 | 0 = SET (allocate), 1 = DELETE |
| req_key_len | input | KEY_W | Key length in bytes |
| req_val_len | input | VAL_W | Value length in bytes |
| req_ready | output | 1 | Request accepted this cycle when valid |
| tail_off | input | clog2(REGION_BYTES) | Oldest live byte offset from reclaim |
| rsp_valid | output | 1 | Allocation result valid |
| rsp_addr | output | ADDR_W | Record start address for the index |
| rsp_wrapped | output | 1 | Record was placed at the base after a wrap |
| wr_valid | output | 1 | Write descriptor valid |
| wr_addr | output | ADDR_W | Header write address |
| wr_len | output | clog2(REGION_BYTES)+1 | Aligned record length in bytes |
| wr_key_addr | output | ADDR_W | Key write address |
| wr_val_addr | output | ADDR_W | Value write address |

## Verification
The tail offset can move in the same cycle that a SET arrives. That same cycle is also when the block decides between appending, wrapping to the base and stalling. The bench drives a new tail value together with each request, both in directed steps and at random: sometimes the tail equals the head, sometimes it is a random aligned offset, and sometimes it is left alone. This pushes requests onto the strict-less-than boundary, onto an exact fill of the region end and onto a wrap. A bench model computes the expected ready level, placement, wrap flag and next head from the tail in that same cycle. It judges `req_ready` mid-cycle and the registered results on the following cycle.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic {
    LSA_OP_SET = 1'b0,
    LSA_OP_DEL = 1'b1
  } lsa_op_e;
endpackage

// File: rtl/lsa_rec_len.sv
// Aligned record length: header + key + value, rounded up to the alignment.
module lsa_rec_len #(
  parameter int KEY_W     = 8,
  parameter int VAL_W     = 12,
  parameter int HDR_BYTES = 16,
  parameter int ALIGN_LG  = 4,
  parameter int LEN_W     = 15
) (
  input  logic [KEY_W-1:0] key_len,
  input  logic [VAL_W-1:0] val_len,
  output logic [LEN_W-1:0] rec_len
);
  logic [LEN_W-1:0] raw_len;

  always_comb begin
    raw_len = LEN_W'(key_len) + LEN_W'(val_len) + LEN_W'(HDR_BYTES);
  end

  generate
    if (ALIGN_LG == 0) begin : g_byte
      assign rec_len = raw_len;
    end else begin : g_round
      localparam logic [LEN_W-1:0] ROUND = LEN_W'((1 << ALIGN_LG) - 1);
      logic [LEN_W-1:0] bumped;
      always_comb begin
        bumped  = raw_len + ROUND;
        rec_len = bumped & ~ROUND;
      end
    end
  endgenerate
endmodule

// File: rtl/lsa_fit.sv
// Free-space check and placement for one record against head and tail.
module lsa_fit #(
  parameter int REGION_BYTES = 16384,
  parameter int OFF_W        = 14
) (
  input  logic [OFF_W-1:0] head,
  input  logic [OFF_W-1:0] tail,
  input  logic [OFF_W:0]   rec_len,
  output logic             fit,
  output logic             wrap,
  output logic [OFF_W-1:0] place,
  output logic [OFF_W-1:0] next_head
);
  localparam logic [OFF_W:0] END_X = (OFF_W+1)'(REGION_BYTES);

  logic [OFF_W:0] head_x;
  logic [OFF_W:0] tail_x;
  logic [OFF_W:0] end_x;
  logic           tail_ahead;
  logic           hits_end;
  logic           fits_before_end;

  always_comb begin
    head_x          = {1'b0, head};
    tail_x          = {1'b0, tail};
    end_x           = head_x + rec_len;
    tail_ahead      = tail_x > head_x;
    hits_end        = end_x == END_X;
    fits_before_end = (end_x < END_X) || (hits_end && (tail != '0));

    wrap      = 1'b0;
    place     = head;
    next_head = hits_end ? '0 : end_x[OFF_W-1:0];
    if (tail_ahead) begin
      fit = end_x < tail_x;
    end else if (fits_before_end) begin
      fit = 1'b1;
    end else begin
      wrap      = 1'b1;
      place     = '0;
      next_head = rec_len[OFF_W-1:0];
      fit       = rec_len < tail_x;
    end
  end
endmodule

// File: rtl/lsa_desc_reg.sv
// Registered response and write descriptor.
module lsa_desc_reg #(
  parameter int              ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0001_0000,
  parameter int              OFF_W       = 14,
  parameter int              KEY_W       = 8,
  parameter int              HDR_BYTES   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              wrap,
  input  logic [OFF_W-1:0]  place,
  input  logic [OFF_W:0]    rec_len,
  input  logic [KEY_W-1:0]  key_len,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_wrapped,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [OFF_W:0]    wr_len,
  output logic [ADDR_W-1:0] wr_key_addr,
  output logic [ADDR_W-1:0] wr_val_addr
);
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] key_addr;

  always_comb begin
    start_addr = REGION_BASE + ADDR_W'(place);
    key_addr   = start_addr + ADDR_W'(HDR_BYTES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      wr_valid    <= 1'b0;
      rsp_addr    <= '0;
      rsp_wrapped <= 1'b0;
      wr_addr     <= '0;
      wr_len      <= '0;
      wr_key_addr <= '0;
      wr_val_addr <= '0;
    end else begin
      rsp_valid <= fire;
      wr_valid  <= fire;
      if (fire) begin
        rsp_addr    <= start_addr;
        rsp_wrapped <= wrap;
        wr_addr     <= start_addr;
        wr_len      <= rec_len;
        wr_key_addr <= key_addr;
        wr_val_addr <= key_addr + ADDR_W'(key_len);
      end
    end
  end
endmodule

// File: rtl/lsa_append_alloc.sv
module lsa_append_alloc
  import lsa_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h0001_0000,
  parameter int                REGION_BYTES = 16384,
  parameter int                HDR_BYTES    = 16,
  parameter int                ALIGN_LG     = 4,
  parameter int                KEY_W        = 8,
  parameter int                VAL_W        = 12
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  input  logic                            req_op,
  input  logic [KEY_W-1:0]                req_key_len,
  input  logic [VAL_W-1:0]                req_val_len,
  output logic                            req_ready,
  input  logic [$clog2(REGION_BYTES)-1:0] tail_off,
  output logic                            rsp_valid,
  output logic [ADDR_W-1:0]               rsp_addr,
  output logic                            rsp_wrapped,
  output logic                            wr_valid,
  output logic [ADDR_W-1:0]               wr_addr,
  output logic [$clog2(REGION_BYTES):0]   wr_len,
  output logic [ADDR_W-1:0]               wr_key_addr,
  output logic [ADDR_W-1:0]               wr_val_addr
);
  localparam int OFF_W = $clog2(REGION_BYTES);
  localparam int LEN_W = OFF_W + 1;

  logic [OFF_W-1:0] head_q;
  logic [LEN_W-1:0] rec_len;
  logic             fit;
  logic             wrap;
  logic [OFF_W-1:0] place;
  logic [OFF_W-1:0] next_head;
  logic             is_del;
  logic             set_fire;

  lsa_rec_len #(
    .KEY_W(KEY_W), .VAL_W(VAL_W), .HDR_BYTES(HDR_BYTES),
    .ALIGN_LG(ALIGN_LG), .LEN_W(LEN_W)
  ) len_i (
    .key_len(req_key_len),
    .val_len(req_val_len),
    .rec_len(rec_len)
  );

  lsa_fit #(
    .REGION_BYTES(REGION_BYTES), .OFF_W(OFF_W)
  ) fit_i (
    .head(head_q),
    .tail(tail_off),
    .rec_len(rec_len),
    .fit(fit),
    .wrap(wrap),
    .place(place),
    .next_head(next_head)
  );

  always_comb begin
    is_del    = req_op == LSA_OP_DEL;
    req_ready = is_del || fit;
    set_fire  = req_valid && !is_del && fit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
    end else if (set_fire) begin
      head_q <= next_head;
    end
  end

  lsa_desc_reg #(
    .ADDR_W(ADDR_W), .REGION_BASE(REGION_BASE), .OFF_W(OFF_W),
    .KEY_W(KEY_W), .HDR_BYTES(HDR_BYTES)
  ) out_i (
    .clk(clk),
    .rst(rst),
    .fire(set_fire),
    .wrap(wrap),
    .place(place),
    .rec_len(rec_len),
    .key_len(req_key_len),
    .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr),
    .rsp_wrapped(rsp_wrapped),
    .wr_valid(wr_valid),
    .wr_addr(wr_addr),
    .wr_len(wr_len),
    .wr_key_addr(wr_key_addr),
    .wr_val_addr(wr_val_addr)
  );
endmodule

// File: rtl/lsa_append_alloc_chk.sv
module lsa_append_alloc_chk
  import lsa_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] REGION_BASE  = 32'h0001_0000,
  parameter int                REGION_BYTES = 16384,
  parameter int                HDR_BYTES    = 16,
  parameter int                ALIGN_LG     = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          req_valid,
  input logic                          req_op,
  input logic                          req_ready,
  input logic                          rsp_valid,
  input logic [ADDR_W-1:0]             rsp_addr,
  input logic                          rsp_wrapped,
  input logic                          wr_valid,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [$clog2(REGION_BYTES):0] wr_len,
  input logic [ADDR_W-1:0]             wr_key_addr,
  input logic [ADDR_W-1:0]             wr_val_addr
);
  localparam logic [ADDR_W-1:0] AMASK   = ADDR_W'((1 << ALIGN_LG) - 1);
  localparam logic [ADDR_W-1:0] END_ADR = REGION_BASE + ADDR_W'(REGION_BYTES);

  logic              seen_q;
  logic [ADDR_W-1:0] exp_next_q;
  logic [ADDR_W-1:0] rec_end;
  logic              set_acc;

  always_comb begin
    rec_end = wr_addr + ADDR_W'(wr_len);
    set_acc = req_valid && req_ready && (req_op == LSA_OP_SET);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q     <= 1'b0;
      exp_next_q <= REGION_BASE;
    end else if (wr_valid) begin
      seen_q     <= 1'b1;
      exp_next_q <= (rec_end == END_ADR) ? REGION_BASE : rec_end;
    end
  end

  AST_SET_GIVES_RESULT: assert property (@(posedge clk) disable iff (rst) set_acc |=> (rsp_valid && wr_valid && (rsp_addr == wr_addr))); // R5
  AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (rst) !set_acc |=> (!wr_valid && !rsp_valid)); // R5
  AST_DELETE_SILENT: assert property (@(posedge clk) disable iff (rst) (req_valid && req_op == LSA_OP_DEL) |=> !wr_valid); // R6
  AST_ALIGNED_RECORD: assert property (@(posedge clk) disable iff (rst) wr_valid |-> ((((wr_addr - REGION_BASE) & AMASK) == '0) && ((ADDR_W'(wr_len) & AMASK) == '0))); // R2
  AST_FIELD_ORDER: assert property (@(posedge clk) disable iff (rst) wr_valid |-> ((wr_key_addr == wr_addr + ADDR_W'(HDR_BYTES)) && (wr_val_addr >= wr_key_addr))); // R3
  AST_SEQUENTIAL_HEAD: assert property (@(posedge clk) disable iff (rst) (wr_valid && seen_q && !rsp_wrapped) |-> (wr_addr == exp_next_q)); // R4
  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst) (rsp_valid && rsp_wrapped) |-> (rsp_addr == REGION_BASE)); // R8
  AST_INSIDE_REGION: assert property (@(posedge clk) disable iff (rst) wr_valid |-> ((wr_addr >= REGION_BASE) && (rec_end <= END_ADR))); // R9
endmodule

bind lsa_append_alloc lsa_append_alloc_chk #(
  .ADDR_W(ADDR_W), .REGION_BASE(REGION_BASE), .REGION_BYTES(REGION_BYTES),
  .HDR_BYTES(HDR_BYTES), .ALIGN_LG(ALIGN_LG)
) chk_i (.*);

// File: tb/lsa_append_alloc_tb_top.sv
`timescale 1ns/1ps
module lsa_append_alloc_tb_top;
  localparam int ADDR_W = 32;
  localparam int BASE   = 32'h0001_0000;
  localparam int REGION = 16384;
  localparam int HDR    = 16;
  localparam int ALIGN  = 16;
  localparam int OFF_W  = $clog2(REGION);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_op = 1'b0;
  logic [7:0] req_key_len = '0;
  logic [11:0] req_val_len = '0;
  logic req_ready;
  logic [OFF_W-1:0] tail_off = '0;
  logic rsp_valid;
  logic [ADDR_W-1:0] rsp_addr;
  logic rsp_wrapped;
  logic wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [OFF_W:0] wr_len;
  logic [ADDR_W-1:0] wr_key_addr;
  logic [ADDR_W-1:0] wr_val_addr;

  int total = 0;
  int bad = 0;
  int h_m = 0;
  int t_m = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lsa_append_alloc dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_key_len(req_key_len), .req_val_len(req_val_len), .req_ready(req_ready),
    .tail_off(tail_off), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_wrapped(rsp_wrapped), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_len(wr_len), .wr_key_addr(wr_key_addr), .wr_val_addr(wr_val_addr)
  );

  task automatic check_eq(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rec_len(int k, int v);
    return ((HDR + k + v + ALIGN - 1) / ALIGN) * ALIGN;
  endfunction

  function automatic void plan(input int h, input int t, input int len,
                               output bit ok, output bit wr, output int place, output int nxt);
    int e;
    e = h + len;
    wr = 0;
    place = h;
    nxt = (e == REGION) ? 0 : e;
    if (t > h) ok = (e < t);
    else if (e < REGION || (e == REGION && t != 0)) ok = 1;
    else begin
      wr = 1; place = 0; nxt = len; ok = (len < t);
    end
  endfunction

  task automatic do_req(bit del, int k, int v, string tag);
    bit ok, wr;
    int place, nxt, len;
    @(negedge clk);
    req_valid = 1'b1;
    req_op = del;
    req_key_len = k[7:0];
    req_val_len = v[11:0];
    tail_off = t_m[OFF_W-1:0];
    #1;
    len = rec_len(k, v);
    plan(h_m, t_m, len, ok, wr, place, nxt);
    check_eq({tag, " R10 ready"}, int'(req_ready), del ? 1 : int'(ok));
    @(negedge clk);
    req_valid = 1'b0;
    if (!del && ok) begin
      check_eq({tag, " R5 rsp_valid"}, int'(rsp_valid), 1);
      check_eq({tag, " R5 wr_valid"}, int'(wr_valid), 1);
      check_eq({tag, " R4 rsp_addr"}, int'(rsp_addr), BASE + place);
      check_eq({tag, " R8 wrapped"}, int'(rsp_wrapped), int'(wr));
      check_eq({tag, " R4 wr_addr"}, int'(wr_addr), BASE + place);
      check_eq({tag, " R2 wr_len"}, int'(wr_len), len);
      check_eq({tag, " R3 key_addr"}, int'(wr_key_addr), BASE + place + HDR);
      check_eq({tag, " R3 val_addr"}, int'(wr_val_addr), BASE + place + HDR + k);
      h_m = nxt;
    end else begin
      check_eq({tag, " R6/R7 rsp_valid"}, int'(rsp_valid), 0);
      check_eq({tag, " R6/R7 wr_valid"}, int'(wr_valid), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rem;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check_eq("R1 rsp_valid in reset", int'(rsp_valid), 0);
    check_eq("R1 wr_valid in reset", int'(wr_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 rsp_valid after reset", int'(rsp_valid), 0);

    t_m = 0;
    do_req(0, 3, 5, "R1 first");
    do_req(0, 0, 0, "R4 second");
    do_req(1, 9, 9, "R6 delete");
    do_req(0, 1, 0, "R6 after delete");
    // R7 strict gap, then R10 tail advance in the same cycle as the request
    t_m = h_m + 16;
    do_req(0, 0, 0, "R7 equal stall");
    t_m = h_m + 32;
    do_req(0, 0, 0, "R10 tail moved");

    // R9 exact fill of region end
    while (REGION - h_m > 527) begin
      t_m = h_m;
      do_req(0, 0, 511, "R4 fill");
    end
    rem = REGION - h_m;
    t_m = 0;
    do_req(0, 0, rem - HDR, "R9 tail zero stall");
    t_m = h_m;
    do_req(0, 0, rem - HDR, "R9 exact fill");
    do_req(0, 2, 2, "R9 after fill");

    // R8 wrap to base
    while (REGION - h_m > 560) begin
      t_m = h_m;
      do_req(0, 0, 511, "R4 fill2");
    end
    rem = REGION - h_m;
    t_m = 16;
    do_req(0, 0, rem, "R8 wrap stall");
    t_m = 1024;
    do_req(0, 0, rem, "R8 wrap");
    t_m = h_m + 16;
    do_req(0, 0, 20, "R7 after wrap");
    t_m = h_m;

    for (int i = 0; i < 800; i++) begin
      int r;
      r = $urandom % 8;
      if (r < 3) t_m = h_m;
      else if (r < 5) t_m = ($urandom % (REGION / ALIGN)) * ALIGN;
      do_req(($urandom % 5) == 0, $urandom % 64, $urandom % 600, "rand");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule